// File: doc/BRIEF.md
# Floating-Point Scoreboard Issue and Hazard Controller

This block is the central hazard controller of an in-order-issue, out-of-order-execute floating-point pipeline. It has five functional units: one integer/load unit, two multipliers, one adder and one divider. Decoded instructions arrive one per cycle on a valid/ready input stream. Each instruction carries an operation class, a destination register and two source registers. The controller keeps a record for every unit: busy, destination, the two source numbers, the producing unit of each source, and a ready flag for each source. It also keeps a table that names, for each of the 32 registers, the unit that will write it.

The controller drives three grant vectors, each with one bit per unit. An issue grant hands the incoming instruction to a unit. A read grant lets a unit fetch its operands and start executing. A write grant lets a finished unit commit its result. Units report the end of execution on a per-unit `done` pulse. Operand values, the register file and the arithmetic are outside this block.

Input stream back-pressure works as follows. The source holds `in_valid` and the instruction fields steady until a cycle in which `in_ready` is high. That cycle is the transfer. `in_ready` is computed from the current fields and the block state, and it does not depend on `in_valid`. Because a stalled instruction holds the stream, no younger instruction can pass it.

Top module: `fp_scoreboard`

## Requirements
- R1: A synchronous active-high reset leaves every unit idle, with no grants asserted. The register owner table is cleared, so `in_ready` is high for any instruction.
- R2: Operation class encoding is 0 = integer/load (unit bit 0), 1 = multiply (bit 1, or bit 2 when bit 1 is busy), 2 = add/subtract (bit 3) and 3 = divide (bit 4). Producer tags inside the block are 1 to 5 for bits 0 to 4, and 0 means no producer. In the transfer cycle exactly one `iss_gnt` bit is high, the bit of the chosen unit. It is never high without a transfer.
- R3: `in_ready` is low while the chosen unit is busy. A unit that is freed by a write is busy for that whole cycle.
- R4: `in_ready` is low while any issued instruction that has not yet written has the same destination register.
- R5: A unit whose sources have no pending producer gets its read grant in the cycle after issue. Several units may get read grants in the same cycle.
- R6: A source with a pending producer blocks the read grant until that producer writes. The read grant comes in the following cycle.
- R7: Each issued instruction gets exactly one read grant, lasting one cycle.
- R8: A write grant comes no earlier than the cycle after the unit's `done` pulse. A unit freed by a write accepts a new instruction in the next cycle.
- R9: A finished unit is denied its write while another busy unit has a source equal to its destination with that source ready but not yet read.
- R10: At most one write grant is given per cycle. Among the eligible units, the lowest bit index wins.
- R11: An instruction that transfers in the same cycle as its source producer writes treats that source as available. Its read grant comes in the next cycle.
- R12: Execute latencies are 1 (integer), 10 (multiply), 2 (add) and 40 (divide), counted from the read grant to the `done` pulse. With these latencies the following six-instruction sequence, the first one offered in cycle 1, makes its last write in cycle 62: load F6; load F2; F0=F2*F4; F8=F6-F2; F10=F0/F6; F6=F8+F2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered on the stream |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_cls | input | 2 | Operation class (see R2) |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| iss_gnt | output | 5 | One-hot unit receiving the transferred instruction |
| rd_gnt | output | 5 | Per-unit read-operands grant |
| wr_gnt | output | 5 | Per-unit write-result grant, at most one high |
| done | input | 5 | Per-unit execution-complete pulse |

## Verification
The bound assertions check the following on every cycle:
- at most one issue grant and one write grant;
- issue only on a transfer, and only to an idle unit;
- read grants only to occupied units, never on two consecutive cycles;
- a write only after that unit has reported completion.

Some behaviour can only be shown by the bench's scenarios:
- that a read waits exactly until its producer's write;
- that a write is held by a pending reader of the old value;
- that WAW and structural stalls release on the right cycle;
- the same-cycle issue-and-write case;
- the 62-cycle reference timing.

The bench shows these by comparing every grant against a behavioural per-instruction model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned NUM_UNITS = 5;
  localparam int unsigned NUM_REGS  = 32;
  localparam int unsigned REG_W     = $clog2(NUM_REGS);
  localparam int unsigned TAG_W     = $clog2(NUM_UNITS + 1);
  localparam int unsigned CLS_W     = 2;

  localparam int unsigned U_INT  = 0;
  localparam int unsigned U_MUL1 = 1;
  localparam int unsigned U_MUL2 = 2;
  localparam int unsigned U_ADD  = 3;
  localparam int unsigned U_DIV  = 4;

  typedef logic [REG_W-1:0]     reg_t;
  typedef logic [TAG_W-1:0]     tag_t;
  typedef logic [NUM_UNITS-1:0] umask_t;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } op_cls_e;
endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
  import sb_pkg::*;
(
  input  logic    in_valid,
  input  op_cls_e cls,
  input  umask_t  busy,
  input  tag_t    dst_owner,
  output logic    ready,
  output umask_t  grant,
  output tag_t    grant_tag
);
  umask_t cand;

  // class to unit steering; second multiplier only when the first is taken
  always_comb begin
    cand = '0;
    case (cls)
      CLS_INT: cand[U_INT] = 1'b1;
      CLS_MUL: begin
        if (!busy[U_MUL1]) cand[U_MUL1] = 1'b1;
        else               cand[U_MUL2] = 1'b1;
      end
      CLS_ADD: cand[U_ADD] = 1'b1;
      default: cand[U_DIV] = 1'b1;
    endcase
  end

  assign ready = ((cand & ~busy) != '0) && (dst_owner == '0);
  assign grant = (in_valid && ready) ? cand : '0;

  always_comb begin
    grant_tag = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (cand[u]) grant_tag = tag_t'(u + 1);
  end
endmodule

// File: rtl/sb_wr_arb.sv
module sb_wr_arb
  import sb_pkg::*;
(
  input  umask_t                busy,
  input  umask_t                fin,
  input  umask_t                rj,
  input  umask_t                rk,
  input  reg_t [NUM_UNITS-1:0]  fi,
  input  reg_t [NUM_UNITS-1:0]  fj,
  input  reg_t [NUM_UNITS-1:0]  fk,
  output umask_t                grant,
  output tag_t                  grant_tag
);
  umask_t elig;

  // a finished unit may commit unless some other unit still needs the old value
  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      elig[u] = busy[u] & fin[u];
      for (int f = 0; f < NUM_UNITS; f++)
        if (f != u && busy[f] &&
            ((fj[f] == fi[u] && rj[f]) || (fk[f] == fi[u] && rk[f])))
          elig[u] = 1'b0;
    end
  end

  // fixed priority, lowest index wins
  always_comb begin
    grant     = '0;
    grant_tag = '0;
    for (int u = int'(NUM_UNITS) - 1; u >= 0; u--)
      if (elig[u]) begin
        grant     = umask_t'(1) << u;
        grant_tag = tag_t'(u + 1);
      end
  end
endmodule

// File: rtl/sb_unit_rec.sv
module sb_unit_rec
  import sb_pkg::*;
#(
  parameter int unsigned MY_TAG = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  reg_t dst,
  input  reg_t s1,
  input  reg_t s2,
  input  tag_t q1,
  input  tag_t q2,
  input  logic rd_go,
  input  tag_t wr_tag,
  input  logic done,
  output logic busy,
  output logic fin,
  output reg_t fi,
  output reg_t fj,
  output reg_t fk,
  output logic rj,
  output logic rk
);
  localparam tag_t SELF = tag_t'(MY_TAG);
  tag_t qj, qk;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; fin <= 1'b0; rj <= 1'b0; rk <= 1'b0;
      qj <= '0; qk <= '0; fi <= '0; fj <= '0; fk <= '0;
    end else if (load) begin
      busy <= 1'b1; fin <= 1'b0;
      fi <= dst; fj <= s1; fk <= s2;
      qj <= q1; qk <= q2;
      rj <= (q1 == '0); rk <= (q2 == '0);
    end else if (wr_tag == SELF) begin
      busy <= 1'b0; fin <= 1'b0; rj <= 1'b0; rk <= 1'b0;
      qj <= '0; qk <= '0;
    end else begin
      if (done && busy) fin <= 1'b1;
      if (rd_go) begin
        rj <= 1'b0; rk <= 1'b0; qj <= '0; qk <= '0;
      end else begin
        if (wr_tag != '0 && qj == wr_tag) begin rj <= 1'b1; qj <= '0; end
        if (wr_tag != '0 && qk == wr_tag) begin rk <= 1'b1; qk <= '0; end
      end
    end
  end
endmodule

// File: rtl/fp_scoreboard.sv
module fp_scoreboard
  import sb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CLS_W-1:0]     in_cls,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src1,
  input  logic [REG_W-1:0]     in_src2,
  output logic [NUM_UNITS-1:0] iss_gnt,
  output logic [NUM_UNITS-1:0] rd_gnt,
  output logic [NUM_UNITS-1:0] wr_gnt,
  input  logic [NUM_UNITS-1:0] done
);
  tag_t                 owner [NUM_REGS];
  umask_t               busy, fin, rj, rk;
  reg_t [NUM_UNITS-1:0] fi, fj, fk;
  tag_t                 iss_tag, wr_tag, q1, q2;
  reg_t                 wr_dst;

  // a producer committing this cycle counts as already done for a new issue
  assign q1 = (wr_tag != '0 && owner[in_src1] == wr_tag) ? '0 : owner[in_src1];
  assign q2 = (wr_tag != '0 && owner[in_src2] == wr_tag) ? '0 : owner[in_src2];

  sb_issue_ctl u_issue (
    .in_valid  (in_valid),
    .cls       (op_cls_e'(in_cls)),
    .busy      (busy),
    .dst_owner (owner[in_dst]),
    .ready     (in_ready),
    .grant     (iss_gnt),
    .grant_tag (iss_tag)
  );

  sb_wr_arb u_warb (
    .busy      (busy),
    .fin       (fin),
    .rj        (rj),
    .rk        (rk),
    .fi        (fi),
    .fj        (fj),
    .fk        (fk),
    .grant     (wr_gnt),
    .grant_tag (wr_tag)
  );

  assign rd_gnt = busy & rj & rk;

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      sb_unit_rec #(.MY_TAG(u + 1)) u_rec (
        .clk    (clk),
        .rst    (rst),
        .load   (iss_gnt[u]),
        .dst    (in_dst),
        .s1     (in_src1),
        .s2     (in_src2),
        .q1     (q1),
        .q2     (q2),
        .rd_go  (rd_gnt[u]),
        .wr_tag (wr_tag),
        .done   (done[u]),
        .busy   (busy[u]),
        .fin    (fin[u]),
        .fi     (fi[u]),
        .fj     (fj[u]),
        .fk     (fk[u]),
        .rj     (rj[u]),
        .rk     (rk[u])
      );
    end
  endgenerate

  always_comb begin
    wr_dst = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (wr_gnt[u]) wr_dst = fi[u];
  end

  // register owner table; WAW stall keeps issue and clear on distinct entries
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) owner[r] <= '0;
    end else begin
      if (wr_gnt != '0)  owner[wr_dst] <= '0;
      if (iss_gnt != '0) owner[in_dst] <= iss_tag;
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [NUM_UNITS-1:0] iss_gnt,
  input logic [NUM_UNITS-1:0] rd_gnt,
  input logic [NUM_UNITS-1:0] wr_gnt,
  input logic [NUM_UNITS-1:0] done
);
  logic [NUM_UNITS-1:0] live, seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      seen <= '0;
    end else begin
      live <= (live | iss_gnt) & ~wr_gnt;
      seen <= (seen | (done & live)) & ~wr_gnt;
    end
  end

  a_r2_single_issue: assert property (@(posedge clk) disable iff (rst)
    $onehot0(iss_gnt));

  a_r3_issue_on_transfer: assert property (@(posedge clk) disable iff (rst)
    (iss_gnt != '0) |-> (in_valid && in_ready));

  a_r3_issue_to_idle: assert property (@(posedge clk) disable iff (rst)
    (iss_gnt & live) == '0);

  a_r5_read_occupied: assert property (@(posedge clk) disable iff (rst)
    (rd_gnt & ~live) == '0);

  a_r7_read_once: assert property (@(posedge clk) disable iff (rst)
    (rd_gnt != '0) |=> ((rd_gnt & $past(rd_gnt)) == '0));

  a_r8_write_after_done: assert property (@(posedge clk) disable iff (rst)
    (wr_gnt & ~seen) == '0);

  a_r10_one_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_gnt));
endmodule

bind fp_scoreboard sb_checker i_sb_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .iss_gnt  (iss_gnt),
  .rd_gnt   (rd_gnt),
  .wr_gnt   (wr_gnt),
  .done     (done)
);

// File: tb/test_fp_scoreboard.sv
`timescale 1ns/1ps
module test_fp_scoreboard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_cls = '0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [4:0] iss_gnt, rd_gnt, wr_gnt;
  logic [4:0] done = '0;

  int checks = 0, fails = 0, cyc_total = 0;
  bit finished = 0;

  // behavioural per-instruction model
  int n_i, nx, nx_dut;
  int m_cls[8], m_dst[8], m_s1[8], m_s2[8], m_u[8], m_p1[8], m_p2[8], m_st[8], m_rdc[8];
  int d_iss[8], d_rd[8], d_wr[8], d_unit[8];
  int owner[5];
  int ref_iss[6] = '{1, 5, 6, 7, 8, 13};
  int ref_rd[6]  = '{2, 6, 9, 9, 21, 14};
  int ref_wr[6]  = '{4, 8, 20, 12, 62, 22};

  always #2.5 clk = ~clk;

  fp_scoreboard i_fp_scoreboard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .iss_gnt(iss_gnt), .rd_gnt(rd_gnt), .wr_gnt(wr_gnt), .done(done)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R12 watchdog: actual %0d cycles expected completion", cyc_total);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lat(int u);
    case (u)
      0:       return 1;
      1, 2:    return 10;
      3:       return 2;
      default: return 40;
    endcase
  endfunction

  function automatic bit src_ok(int p);
    return p < 0 || m_st[p] == 4;
  endfunction

  function automatic bit unit_busy(int u);
    for (int i = 0; i < n_i; i++)
      if (m_u[i] == u && m_st[i] >= 1 && m_st[i] <= 3) return 1;
    return 0;
  endfunction

  function automatic int producer(int r);
    for (int i = 0; i < n_i; i++)
      if (m_st[i] >= 1 && m_st[i] <= 3 && m_dst[i] == r) return i;
    return -1;
  endfunction

  task automatic add_i(int cls, int d, int a, int b);
    m_cls[n_i] = cls; m_dst[n_i] = d; m_s1[n_i] = a; m_s2[n_i] = b;
    m_u[n_i] = -1; m_st[n_i] = 0; m_rdc[n_i] = 0;
    d_iss[n_i] = -1; d_rd[n_i] = -1; d_wr[n_i] = -1; d_unit[n_i] = -1;
    n_i++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; done = '0;
    in_cls = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset issue grant", iss_gnt, 0);
    chk("R1 reset read grant", rd_gnt, 0);
    chk("R1 reset write grant", wr_gnt, 0);
    chk("R1 reset ready", in_ready, 1);
    n_i = 0;
  endtask

  task automatic run(int limit);
    int wi, iu;
    bit alldone, blk, e_rdy;
    logic [4:0] e_done, e_rd, e_wr, e_iss;
    nx = 0; nx_dut = 0;
    for (int u = 0; u < 5; u++) owner[u] = -1;
    alldone = 0;
    for (int c = 1; c <= limit; c++) begin
      alldone = (nx == n_i);
      for (int i = 0; i < n_i; i++) if (m_st[i] != 4) alldone = 0;
      if (alldone) break;
      @(negedge clk);
      e_done = '0;
      for (int i = 0; i < n_i; i++)
        if (m_st[i] == 2 && c == m_rdc[i] + lat(m_u[i])) e_done[m_u[i]] = 1'b1;
      e_rd = '0;
      for (int i = 0; i < n_i; i++)
        if (m_st[i] == 1 && src_ok(m_p1[i]) && src_ok(m_p2[i])) e_rd[m_u[i]] = 1'b1;
      e_wr = '0; wi = -1;
      for (int i = 0; i < n_i; i++)
        if (m_st[i] == 3) begin
          blk = 0;
          for (int j = 0; j < n_i; j++)
            if (j != i && m_st[j] == 1 &&
                ((m_s1[j] == m_dst[i] && src_ok(m_p1[j])) ||
                 (m_s2[j] == m_dst[i] && src_ok(m_p2[j])))) blk = 1;
          if (!blk && (wi < 0 || m_u[i] < m_u[wi])) wi = i;
        end
      if (wi >= 0) e_wr[m_u[wi]] = 1'b1;
      e_iss = '0; e_rdy = 0; iu = -1;
      if (nx < n_i) begin
        case (m_cls[nx])
          0:       iu = 0;
          1:       iu = unit_busy(1) ? 2 : 1;
          2:       iu = 3;
          default: iu = 4;
        endcase
        e_rdy = !unit_busy(iu) && (producer(m_dst[nx]) < 0);
        if (e_rdy) e_iss[iu] = 1'b1;
        in_valid = 1'b1; in_cls = 2'(m_cls[nx]);
        in_dst = 5'(m_dst[nx]); in_src1 = 5'(m_s1[nx]); in_src2 = 5'(m_s2[nx]);
      end else begin
        in_valid = 1'b0; in_cls = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
      end
      done = e_done;
      #1;
      if (nx < n_i) chk("R3 R4 in_ready", in_ready, e_rdy);
      chk("R2 R3 issue grant", iss_gnt, e_iss);
      chk("R5 R6 R7 read grant", rd_gnt, e_rd);
      chk("R8 R9 R10 write grant", wr_gnt, e_wr);
      for (int u = 0; u < 5; u++) begin
        if (rd_gnt[u] && owner[u] >= 0) d_rd[owner[u]] = c;
        if (wr_gnt[u] && owner[u] >= 0) d_wr[owner[u]] = c;
      end
      for (int u = 0; u < 5; u++)
        if (iss_gnt[u] && nx_dut < n_i) begin
          owner[u] = nx_dut; d_iss[nx_dut] = c; d_unit[nx_dut] = u; nx_dut++;
        end
      // advance the model by its own decisions
      for (int i = 0; i < n_i; i++)
        if (m_st[i] == 2 && e_done[m_u[i]]) m_st[i] = 3;
      for (int i = 0; i < n_i; i++)
        if (m_st[i] == 1 && e_rd[m_u[i]]) begin m_st[i] = 2; m_rdc[i] = c; end
      if (e_rdy && nx < n_i) begin
        m_p1[nx] = producer(m_s1[nx]);
        m_p2[nx] = producer(m_s2[nx]);
        m_u[nx] = iu; m_st[nx] = 1; nx++;
      end
      if (wi >= 0) m_st[wi] = 4;
    end
    alldone = (nx == n_i);
    for (int i = 0; i < n_i; i++) if (m_st[i] != 4) alldone = 0;
    chk("R12 sequence retired", alldone, 1);
    in_valid = 1'b0; done = '0;
  endtask

  initial begin
    int last;
    repeat (3) @(posedge clk);
    do_reset();

    // scenario A: six-instruction reference sequence
    add_i(0, 6, 18, 18); add_i(0, 2, 19, 19); add_i(1, 0, 2, 4);
    add_i(2, 8, 6, 2);   add_i(3, 10, 0, 6);  add_i(2, 6, 8, 2);
    run(300);
    for (int i = 0; i < 6; i++) begin
      chk("R12 reference issue cycle", d_iss[i], ref_iss[i]);
      chk("R12 reference read cycle", d_rd[i], ref_rd[i]);
      chk("R12 reference write cycle", d_wr[i], ref_wr[i]);
    end
    last = 0;
    for (int i = 0; i < 6; i++) if (d_wr[i] > last) last = d_wr[i];
    chk("R12 last write cycle", last, 62);
    chk("R3 structural stall of second load", d_iss[1], 5);
    chk("R6 multiply reads after load write", d_rd[2], 9);
    chk("R5 two units read together", d_rd[3], d_rd[2]);
    chk("R9 add write held for divide read", d_wr[5], 22);

    // scenario B: second multiplier, WAW stall, same-cycle bypass
    do_reset();
    add_i(1, 1, 20, 21); add_i(1, 3, 20, 21); add_i(2, 1, 3, 20); add_i(3, 12, 1, 1);
    run(300);
    chk("R2 first multiply to unit 1", d_unit[0], 1);
    chk("R2 busy multiplier steers to unit 2", d_unit[1], 2);
    chk("R4 WAW stall release cycle", d_iss[2], 14);
    chk("R11 read after same-cycle producer write", d_rd[2], 15);
    chk("R6 divide waits for add write", d_rd[3], d_wr[2] + 1);

    // scenario C: write collision priority and unit reuse
    do_reset();
    add_i(2, 7, 20, 21); add_i(0, 9, 20, 21); add_i(0, 11, 7, 9);
    run(300);
    chk("R5 read in cycle after issue", d_rd[0], 2);
    chk("R10 integer unit wins collision", d_wr[1], 5);
    chk("R10 adder deferred one cycle", d_wr[0], 6);
    chk("R8 freed unit reissued next cycle", d_iss[2], 6);
    chk("R11 source written at issue reads next cycle", d_rd[2], 7);

    do_reset();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule